// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers the one-cycle event strobes raised by an I2C master controller core and holds them as sticky flags in a 16-bit status word. Software sees the same pending events in two ways. The first is a bit-mapped status register that it clears by writing ones, paired with an enable mask that decides which events drive the single interrupt output. The second is a legacy vector register. It returns a small code for the most urgent pending event among the five basic ones, and reading it clears that event.

A bus-busy input is mirrored live into the status word; no write affects it. All register reads are registered, so read data appears one cycle after the read strobe. The interrupt output is also registered.

Top module: `i2c_irq_status_unit`

## Requirements
- R1: After synchronous reset, the status, enable and vector views all read zero and `irq` is low.
- R2: A one on `evt_pulse[i]` sets sticky status bit i on the next clock edge, for i in {0 arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain}. Strobes on bits 5-7, 12 and 15 have no effect, and those bits never hold a sticky flag.
- R3: The enable register (address 1) stores only bits 0-4, 13 and 14 of a write. Every other bit reads as zero.
- R4: Writing the status register (address 0) clears every sticky bit written as one and leaves every bit written as zero unchanged.
- R5: Status bit 12 reads the level of `bus_busy` at the read cycle. Writes to the status register do not change it.
- R6: `irq` is the registered OR of (status AND enable). It rises one clock after the enabled status bit becomes visible.
- R7: Writing zero to the enable register drops `irq` but keeps every pending status bit. Enabling again raises `irq` again.
- R8: Reading the vector register (address 2) returns a code in bits 2:0: 0 none, 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready. When several are pending, the lowest nonzero code is reported. The enable mask plays no part.
- R9: A vector read clears only the status bit it reports. Bits 8-14 never appear in the vector and are left untouched.
- R10: An event strobe in the same cycle as a clear of that bit, by status write or by vector read, leaves the bit set.
- R11: `reg_rdata` updates on the clock after `reg_rd` and holds between reads. Address 3 reads zero, and writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 16 | One-cycle event strobes, indexed by status bit |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Registered interrupt request |

## Verification
Two clears can fall in the same cycle as a new strobe for the same bit. One is a write-one-to-clear of the status register; the other is a vector read that clears the event it reports. The bench drives the strobe and the clearing access on the same falling edge, so both are sampled at one rising edge. It then reads the status back and expects the bit still set. For the vector case it also expects the read to have returned the colliding event's code.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int VEC_N  = 5;
  localparam int VEC_W  = 3;
  localparam int B_BUSY = 12;
  // sticky event positions: 0-4, 8-11, 13, 14
  localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;
  // interrupt-capable positions: 0-4, 13, 14
  localparam logic [REG_W-1:0] IRQ_MASK    = 16'h601F;
  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_VECTOR = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         sts[i] <= 1'b0;
        else if (ev[i])  sts[i] <= 1'b1;
        else if (clr[i]) sts[i] <= 1'b0;
      end

      // R2 R10
      ev_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> sts[i]);
      // R4
      clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !ev[i]) |=> !sts[i]);
    end else begin : g_zero
      assign sts[i] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_vec_enc.sv
module i2c_irq_vec_enc #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0]  pend,
  output logic [CW-1:0] code,
  output logic [N-1:0]  sel
);
  always_comb begin
    code = '0;
    sel  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        code   = CW'(i + 1);
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_status_unit.sv
module i2c_irq_status_unit
  import i2c_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter int NV = VEC_N,
  parameter int CW = VEC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] evt_pulse,
  input  logic          bus_busy,
  output logic          irq
);
  localparam int PAD = DW - NV;

  logic [DW-1:0] sts;
  logic [DW-1:0] clr;
  logic [DW-1:0] en_q;
  logic [DW-1:0] view;
  logic [CW-1:0] vec_code;
  logic [NV-1:0] vec_sel;
  logic          wr_sts, wr_en, rd_vec;

  assign wr_sts = reg_wr && (reg_addr == A_STATUS);
  assign wr_en  = reg_wr && (reg_addr == A_ENABLE);
  assign rd_vec = reg_rd && (reg_addr == A_VECTOR);

  i2c_irq_vec_enc #(.N(NV), .CW(CW)) u_enc (
    .pend (sts[NV-1:0]),
    .code (vec_code),
    .sel  (vec_sel)
  );

  assign clr = (wr_sts ? reg_wdata : '0) |
               (rd_vec ? {{PAD{1'b0}}, vec_sel} : '0);

  i2c_irq_sticky #(.W(DW), .MASK(STICKY_MASK)) u_sticky (
    .clk (clk),
    .rst (rst),
    .ev  (evt_pulse),
    .clr (clr),
    .sts (sts)
  );

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= reg_wdata & IRQ_MASK;
  end

  always_comb begin
    view         = sts;
    view[B_BUSY] = bus_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STATUS: reg_rdata <= view;
        A_ENABLE: reg_rdata <= en_q;
        A_VECTOR: reg_rdata <= {{(DW-CW){1'b0}}, vec_code};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts & en_q);
  end

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(|en_q) |-> !irq);
  // R5
  busy_live_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_STATUS) |=> (reg_rdata[B_BUSY] == $past(bus_busy)));
  // R8
  vec_code_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_code <= CW'(NV)) && ((vec_code != '0) == (|sts[NV-1:0])));
  // R3
  en_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_ENABLE) |=> ((reg_rdata & ~IRQ_MASK) == '0));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_NONE) |=> (reg_rdata == '0));
endmodule

// File: tb/i2c_irq_status_unit_tb.sv
module i2c_irq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] evt_pulse = '0;
  logic        bus_busy = 1'b0;
  logic        irq;
  logic        rd_fire = 1'b0;
  logic        done = 1'b0;
  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  i2c_irq_status_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .bus_busy(bus_busy), .irq(irq)
  );

  // monitor: read data is valid after the edge that sampled reg_rd
  always @(posedge clk) rd_fire <= reg_rd;
  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(0, 16'h0000, "R1 status");
    rd(1, 16'h0000, "R1 enable");
    rd(2, 16'h0000, "R1 vector");
    // R2 arbitration lost sets bit 0; enable still zero keeps irq low
    pulse(16'h0001);
    rd(0, 16'h0001, "R2 bit0 set");
    chk_irq(1'b0, "R6 masked by zero enable");
    // R3 enable positions
    wr(1, 16'hFFFF);
    rd(1, 16'h601F, "R3 enable stores 0-4,13,14");
    // R6 irq asserted
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R6 irq from enabled status");
    // R7 mask retains status
    wr(1, 16'h0000);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R7 irq masked");
    rd(0, 16'h0001, "R7 status kept");
    wr(1, 16'h601F);
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R7 irq back");
    // R4 write zero keeps, write one clears
    wr(0, 16'h0000);
    rd(0, 16'h0001, "R4 zero write keeps");
    wr(0, 16'h0001);
    rd(0, 16'h0000, "R4 one write clears");
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R6 irq drops after clear");
    // R5 bus busy live
    @(negedge clk); bus_busy = 1'b1;
    wr(0, 16'h1000);
    rd(0, 16'h1000, "R5 busy live despite write");
    @(negedge clk); bus_busy = 1'b0;
    rd(0, 16'h0000, "R5 busy follows input");
    // R2 all strobes: only sticky positions hold
    pulse(16'hFFFF);
    rd(0, 16'h6F1F, "R2 sticky positions only");
    // R8 R9 vector priority and clear
    rd(2, 16'h0001, "R8 vector code 1 first");
    rd(2, 16'h0002, "R8 vector code 2");
    rd(2, 16'h0003, "R8 vector code 3");
    rd(2, 16'h0004, "R8 vector code 4");
    rd(2, 16'h0005, "R8 vector code 5");
    rd(2, 16'h0000, "R9 upper bits not in vector");
    rd(0, 16'h6F00, "R9 upper bits untouched");
    wr(0, 16'hFFFF);
    rd(0, 16'h0000, "R4 clear all");
    // R8 vector ignores enable mask
    wr(1, 16'h0000);
    pulse(16'h0018);
    rd(2, 16'h0004, "R8 vector with enable zero");
    rd(0, 16'h0010, "R9 only reported bit cleared");
    // R6 drain event drives irq
    wr(0, 16'hFFFF);
    wr(1, 16'h2000);
    pulse(16'h2000);
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R6 receive drain irq");
    wr(0, 16'h2000);
    // R10 strobe collides with status write
    @(negedge clk); evt_pulse = 16'h0004; reg_wr = 1'b1; reg_addr = 0; reg_wdata = 16'h0004;
    @(negedge clk); evt_pulse = '0; reg_wr = 1'b0;
    rd(0, 16'h0004, "R10 strobe wins over write clear");
    wr(0, 16'h0004);
    // R10 strobe collides with vector read
    pulse(16'h0001);
    @(negedge clk); evt_pulse = 16'h0001; reg_rd = 1'b1; reg_addr = 2;
    exp_q.push_back(16'h0001); tag_q.push_back("R10 vector code on collision");
    @(negedge clk); evt_pulse = '0; reg_rd = 1'b0;
    rd(0, 16'h0001, "R10 strobe wins over vector clear");
    // R11 unmapped address and ignored writes
    wr(2, 16'hFFFF);
    wr(3, 16'hFFFF);
    rd(3, 16'h0000, "R11 unmapped reads zero");
    rd(0, 16'h0001, "R11 writes to 2/3 change nothing");
    rd(1, 16'h2000, "R11 enable unchanged");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule